// File: doc/BRIEF.md
# Performance Counter Bank with Set/Clear Mask Registers

This block holds a configurable number of 32-bit event counters and one 64-bit cycle counter. Software reaches all of them through a plain request/write/address/data port. Each general counter advances on a one-cycle pulse from its own event input. The cycle counter advances on every clock while it is enabled.

One global control register starts and stops counting and can zero the counters. Three mask registers hold the per-counter state: counting enable, interrupt enable and overflow status. Each mask has one address that sets bits and another address that clears them, so software never has to read, modify and write a mask.

When a counter wraps, it flags its overflow bit. A single interrupt line is raised for every flagged counter whose interrupt is enabled. In every mask the general counters occupy the low bits and the cycle counter occupies bit 31.

Top module: `perf_counter_bank`

## Requirements
- R1: Control register at 0x400. Bit 0 is the global count enable. A write with bit 1 set zeroes all general counters, and a write with bit 2 set zeroes the cycle counter, so writing 0x6 zeroes every counter. Zeroing takes priority over increments in the same cycle.
- R2: Bits 15:11 of the control register read back NUM_GEN, and writes to that field have no effect. After reset the control register reads NUM_GEN<<11.
- R3: A general counter advances by one only in a cycle where its event pulse is 1, the global enable is 1 and its own enable bit is 1. The cycle counter advances by one on every clock in which the global enable and mask bit 31 are both 1.
- R4: In each mask, bit i (i < NUM_GEN) belongs to general counter i and bit 31 belongs to the cycle counter. All other bits read 0, and writes to them are ignored.
- R5: The counting-enable mask is cleared at 0x403 and set at 0x404. The interrupt-enable mask is cleared at 0x405 and set at 0x406. The overflow mask is cleared at 0x407 and set at 0x408. A 1 in the write data changes that bit and a 0 leaves it unchanged. Either address of a pair reads the current mask.
- R6: A counter that advances from all ones to zero sets its overflow bit at that same clock edge. A hardware set in the same cycle as a software clear of that bit wins.
- R7: irq_o is 1 exactly when some bit is 1 in both the overflow mask and the interrupt-enable mask. It stays 1 until those bits are cleared.
- R8: General counter i has a 32-bit read/write control register at 0x420+0x10*i and a 32-bit read/write value at 0x421+0x10*i, read zero-extended to 64 bits. The cycle counter has a 32-bit read/write control register at 0x409 and a 64-bit read/write value at 0x40A. A software write to a value wins over an increment in the same cycle and sets no overflow bit.
- R9: Reads from any other offset return 0, and writes to them change no state.
- R10: A read accepted at a clock edge returns, on rdata_o after that edge, the state as it was before that edge. rdata_o holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_GEN | One-cycle increment pulse per general counter |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Register offset |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The assertions check several behaviours on every cycle. A counter holds its value whenever it is not running, written or zeroed, and it reads zero after a wrap. A wrap lands in the overflow mask, a clear-address write removes the bits it names, the interrupt holds until an overflow or interrupt-enable clear arrives, and a control read returns the counter count. Other behaviours appear only in the bench scenarios, where a behavioural reference model is compared every clock: the exact count values under mixed event patterns, a wrap colliding with a software clear, counter zeroing through the control register, the silence of unmapped offsets, and the 64-bit carry of the cycle counter.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W = 12;
  localparam int MASK_W = 32;
  localparam int CYC_BIT = 31;
  localparam int NUM_FIELD_LSB = 11;
  localparam int GEN_STRIDE_LOG2 = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
  localparam logic [ADDR_W-1:0] A_CE_CLR  = 12'h403;
  localparam logic [ADDR_W-1:0] A_CE_SET  = 12'h404;
  localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h405;
  localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h406;
  localparam logic [ADDR_W-1:0] A_OV_CLR  = 12'h407;
  localparam logic [ADDR_W-1:0] A_OV_SET  = 12'h408;
  localparam logic [ADDR_W-1:0] A_CYC_CTL = 12'h409;
  localparam logic [ADDR_W-1:0] A_CYC_VAL = 12'h40A;
  localparam logic [ADDR_W-1:0] A_GEN_BASE = 12'h420;

  // implemented mask bits: general counters low, cycle counter at bit 31
  function automatic logic [MASK_W-1:0] mask_valid(int n);
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  logic [W-1:0] value_q;

  assign wrap_o  = run_i & inc_i & ~wr_i & ~clr_i & (&value_q);
  assign value_o = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               value_q <= '0;
    else if (clr_i)            value_q <= '0;
    else if (wr_i)             value_q <= wdata_i;
    else if (run_i && inc_i)   value_q <= value_q + 1'b1;
  end

  // R3: no advance without run and pulse
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && inc_i) && !wr_i && !clr_i) |=> $stable(value_o));

  // R6: wrap lands on zero
  a_r6_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (value_o == '0));
endmodule

// File: rtl/pcb_mask.sv
module pcb_mask #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, set_bits, clr_bits;

  assign set_bits = set_i ? wdata_i : '0;
  assign clr_bits = clr_i ? wdata_i : '0;
  assign q_o      = q_q;

  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr_bits) | set_bits | hw_set_i) & VALID;
  end

  // R5: clear address removes named bits unless hardware sets them
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(wdata_i & ~hw_set_i)) == '0));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_GEN = 4,
  parameter int GEN_W   = 32,
  parameter int CTL_W   = 32,
  parameter int CYC_W   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GEN-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [CYC_W-1:0]   wdata_i,
  output logic [CYC_W-1:0]   rdata_o,
  output logic               irq_o
);
  import pcb_pkg::*;

  localparam logic [MASK_W-1:0] VALID = mask_valid(NUM_GEN);
  localparam logic [4:0]        NUM_FIELD = 5'(NUM_GEN);

  logic wr, rd, en_q, clr_gen, clr_cyc;
  logic [ADDR_W-1:0] gen_off;
  logic [ADDR_W-GEN_STRIDE_LOG2-1:0] gen_idx;
  logic gen_hit;
  logic [MASK_W-1:0] ce_q, ie_q, ov_q, hw_ovf, wd_mask;
  logic [NUM_GEN-1:0] gen_wrap;
  logic cyc_wrap;
  logic [GEN_W-1:0] gen_val [NUM_GEN];
  logic [CTL_W-1:0] gen_ctl [NUM_GEN];
  logic [CYC_W-1:0] cyc_val;
  logic [CTL_W-1:0] cyc_ctl;
  logic [CYC_W-1:0] rd_val, rdata_q;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign gen_off = addr_i - A_GEN_BASE;
  assign gen_idx = gen_off[ADDR_W-1:GEN_STRIDE_LOG2];
  assign gen_hit = (addr_i >= A_GEN_BASE) && (int'(gen_idx) < NUM_GEN);
  assign clr_gen = wr && (addr_i == A_CTRL) && wdata_i[1];
  assign clr_cyc = wr && (addr_i == A_CTRL) && wdata_i[2];
  assign wd_mask = wdata_i[MASK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= 1'b0;
    else if (wr && addr_i == A_CTRL)    en_q <= wdata_i[0];
  end

  // general counters and their control registers
  for (genvar i = 0; i < NUM_GEN; i++) begin : g_gen
    logic sel_val, sel_ctl;
    assign sel_val = wr && gen_hit && (int'(gen_idx) == i) && (gen_off[3:0] == 4'h1);
    assign sel_ctl = wr && gen_hit && (int'(gen_idx) == i) && (gen_off[3:0] == 4'h0);

    pcb_counter #(.W(GEN_W)) u_ctr (
      .clk_i, .rst_ni,
      .run_i  (en_q & ce_q[i]),
      .inc_i  (evt_i[i]),
      .wr_i   (sel_val),
      .wdata_i(wdata_i[GEN_W-1:0]),
      .clr_i  (clr_gen),
      .value_o(gen_val[i]),
      .wrap_o (gen_wrap[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      gen_ctl[i] <= '0;
      else if (sel_ctl) gen_ctl[i] <= wdata_i[CTL_W-1:0];
    end

    // R6: wrap shows in the overflow mask after the edge
    a_r6_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_wrap[i] |=> ov_q[i]);
  end

  pcb_counter #(.W(CYC_W)) u_cyc (
    .clk_i, .rst_ni,
    .run_i  (en_q & ce_q[CYC_BIT]),
    .inc_i  (1'b1),
    .wr_i   (wr && addr_i == A_CYC_VAL),
    .wdata_i(wdata_i),
    .clr_i  (clr_cyc),
    .value_o(cyc_val),
    .wrap_o (cyc_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cyc_ctl <= '0;
    else if (wr && addr_i == A_CYC_CTL)  cyc_ctl <= wdata_i[CTL_W-1:0];
  end

  always_comb begin
    hw_ovf = '0;
    hw_ovf[NUM_GEN-1:0] = gen_wrap;
    hw_ovf[CYC_BIT] = cyc_wrap;
  end

  pcb_mask #(.W(MASK_W), .VALID(VALID)) u_ce (
    .clk_i, .rst_ni,
    .set_i(wr && addr_i == A_CE_SET), .clr_i(wr && addr_i == A_CE_CLR),
    .wdata_i(wd_mask), .hw_set_i('0), .q_o(ce_q));

  pcb_mask #(.W(MASK_W), .VALID(VALID)) u_ie (
    .clk_i, .rst_ni,
    .set_i(wr && addr_i == A_IE_SET), .clr_i(wr && addr_i == A_IE_CLR),
    .wdata_i(wd_mask), .hw_set_i('0), .q_o(ie_q));

  pcb_mask #(.W(MASK_W), .VALID(VALID)) u_ov (
    .clk_i, .rst_ni,
    .set_i(wr && addr_i == A_OV_SET), .clr_i(wr && addr_i == A_OV_CLR),
    .wdata_i(wd_mask), .hw_set_i(hw_ovf), .q_o(ov_q));

  assign irq_o = |(ov_q & ie_q);

  // read decode
  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      A_CTRL: begin
        rd_val[0] = en_q;
        rd_val[NUM_FIELD_LSB +: 5] = NUM_FIELD;
      end
      A_CE_CLR, A_CE_SET: rd_val[MASK_W-1:0] = ce_q;
      A_IE_CLR, A_IE_SET: rd_val[MASK_W-1:0] = ie_q;
      A_OV_CLR, A_OV_SET: rd_val[MASK_W-1:0] = ov_q;
      A_CYC_CTL:          rd_val[CTL_W-1:0]  = cyc_ctl;
      A_CYC_VAL:          rd_val             = cyc_val;
      default: begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (gen_hit && int'(gen_idx) == i) begin
            if (gen_off[3:0] == 4'h0)      rd_val[CTL_W-1:0] = gen_ctl[i];
            else if (gen_off[3:0] == 4'h1) rd_val[GEN_W-1:0] = gen_val[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  // R7: interrupt sticks until a clear arrives
  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr && (addr_i == A_OV_CLR || addr_i == A_IE_CLR))) |=> irq_o);

  // R2: control read reports counter count
  a_r2_num_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_CTRL) |=> (rdata_o[NUM_FIELD_LSB +: 5] == NUM_FIELD));
endmodule

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;
  localparam int NG = 4;
  localparam logic [31:0] VALID = 32'h8000_000F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NG-1:0] evt = '0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic irq;

  always #2.5 clk = ~clk;

  perf_counter_bank #(.NUM_GEN(NG)) u_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  int nchk = 0, nerr = 0;
  string cur_tag = "R10";

  // reference model state
  int unsigned m_gen [NG];
  int unsigned m_gctl [NG];
  longint unsigned m_cyc;
  int unsigned m_cctl;
  bit m_en;
  bit [31:0] m_ce, m_ie, m_ov;
  longint unsigned m_rdata;
  bit m_rd_v;
  string m_tag;

  function automatic longint unsigned mread(logic [11:0] a);
    case (a)
      12'h400: return longint'(m_en) | (longint'(NG) << 11);
      12'h403, 12'h404: return longint'(m_ce);
      12'h405, 12'h406: return longint'(m_ie);
      12'h407, 12'h408: return longint'(m_ov);
      12'h409: return longint'(m_cctl);
      12'h40A: return m_cyc;
      default: begin
        for (int i = 0; i < NG; i++) begin
          if (a == 12'h420 + 12'(16*i)) return longint'(m_gctl[i]);
          if (a == 12'h421 + 12'(16*i)) return longint'(m_gen[i]);
        end
        return 0;
      end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) begin m_gen[i] = 0; m_gctl[i] = 0; end
      m_cyc = 0; m_cctl = 0; m_en = 0; m_ce = 0; m_ie = 0; m_ov = 0;
      m_rdata = 0; m_rd_v = 0;
    end else begin
      bit w;
      bit [31:0] hw, wd;
      w = req && we;
      wd = wdata[31:0];
      hw = 0;
      m_rd_v = req && !we;
      if (m_rd_v) begin m_rdata = mread(addr); m_tag = cur_tag; end
      for (int i = 0; i < NG; i++) begin
        if (w && addr == 12'h400 && wdata[1]) m_gen[i] = 0;
        else if (w && addr == 12'h421 + 12'(16*i)) m_gen[i] = wd;
        else if (m_en && m_ce[i] && evt[i]) begin
          if (m_gen[i] == 32'hFFFF_FFFF) hw[i] = 1;
          m_gen[i] = m_gen[i] + 1;
        end
        if (w && addr == 12'h420 + 12'(16*i)) m_gctl[i] = wd;
      end
      if (w && addr == 12'h400 && wdata[2]) m_cyc = 0;
      else if (w && addr == 12'h40A) m_cyc = wdata;
      else if (m_en && m_ce[31]) begin
        if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) hw[31] = 1;
        m_cyc = m_cyc + 1;
      end
      if (w && addr == 12'h409) m_cctl = wd;
      if (w && addr == 12'h403) m_ce = m_ce & ~wd;
      if (w && addr == 12'h404) m_ce = (m_ce | wd) & VALID;
      if (w && addr == 12'h405) m_ie = m_ie & ~wd;
      if (w && addr == 12'h406) m_ie = (m_ie | wd) & VALID;
      if (w && addr == 12'h407) m_ov = m_ov & ~wd;
      if (w && addr == 12'h408) m_ov = m_ov | wd;
      m_ov = (m_ov | hw) & VALID;
      if (w && addr == 12'h400) m_en = wdata[0];
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      nchk++;
      if (irq !== |(m_ov & m_ie)) begin
        nerr++;
        $display("FAIL R7 irq_o actual=%0b expected=%0b", irq, |(m_ov & m_ie));
      end
      if (m_rd_v) begin
        nchk++;
        if (rdata !== m_rdata) begin
          nerr++;
          $display("FAIL %s rdata_o actual=%h expected=%h", m_tag, rdata, m_rdata);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [NG-1:0] ev = '0);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; evt = ev;
    @(negedge clk);
    req = 0; we = 0; evt = '0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic pulse(input logic [NG-1:0] ev, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt = ev ^ NG'(k);
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic dump(input string tag);
    rd(12'h400, tag); rd(12'h404, tag); rd(12'h406, tag); rd(12'h408, tag);
    rd(12'h40A, tag); rd(12'h409, tag);
    for (int i = 0; i < NG; i++) begin
      rd(12'h421 + 12'(16*i), tag); rd(12'h420 + 12'(16*i), tag);
    end
  endtask

  initial begin
    #(5ns * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state and read-only field
    rd(12'h400, "R2");
    wr(12'h400, 64'h0000_F800);
    rd(12'h400, "R2");
    dump("R10");
    // R4 unused mask bits
    wr(12'h404, 64'hFFFF_FFFF);
    rd(12'h403, "R4");
    // R5 clear one bit, zeros untouched
    wr(12'h403, 64'h0000_0002);
    rd(12'h404, "R5");
    wr(12'h406, 64'h0000_0001);
    rd(12'h405, "R5");
    // R3 counting under several patterns
    pulse(4'b1111, 6);
    rd(12'h421, "R3");
    wr(12'h400, 64'h1);
    pulse(4'b1011, 9);
    pulse(4'b0110, 7);
    dump("R3");
    wr(12'h400, 64'h0);
    pulse(4'b1111, 5);
    dump("R3");
    // R8 register read/write
    wr(12'h420, 64'hDEAD_BEEF);
    wr(12'h450, 64'h1234_5678);
    wr(12'h409, 64'hCAFE_F00D_A5A5_0001);
    wr(12'h431, 64'hFFFF_FFFF_0000_0042);
    dump("R8");
    // R6 wrap of counter 0 while enabled
    wr(12'h421, 64'hFFFF_FFFE);
    wr(12'h400, 64'h1);
    pulse(4'b0001, 3);
    rd(12'h408, "R6");
    rd(12'h421, "R6");
    // R7 interrupt raised, held, then cleared
    repeat (4) @(negedge clk);
    wr(12'h407, 64'h1);
    rd(12'h408, "R7");
    // R6 wrap colliding with a clear of the same bit
    wr(12'h403, 64'hFFFF_FFFF);
    wr(12'h404, 64'h1);
    wr(12'h421, 64'hFFFF_FFFF);
    wr(12'h407, 64'h1, 4'b0001);
    rd(12'h408, "R6");
    // R8 software write beats increment
    wr(12'h421, 64'h0000_0010, 4'b0001);
    rd(12'h421, "R8");
    // R6 cycle counter 64-bit carry and wrap
    wr(12'h40A, 64'h0000_0000_FFFF_FFFE);
    wr(12'h404, 64'h8000_0000);
    rd(12'h40A, "R3");
    wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFD);
    wr(12'h406, 64'h8000_0000);
    repeat (3) @(negedge clk);
    rd(12'h408, "R6");
    // R5 set via software
    wr(12'h407, 64'hFFFF_FFFF);
    wr(12'h408, 64'h0000_0004);
    rd(12'h407, "R5");
    wr(12'h406, 64'h4);
    wr(12'h405, 64'hFFFF_FFFF);
    rd(12'h406, "R5");
    // R1 zero every counter
    pulse(4'b1111, 4);
    wr(12'h400, 64'h6, 4'b1111);
    dump("R1");
    wr(12'h400, 64'h5);
    pulse(4'b1111, 3);
    wr(12'h400, 64'h3);
    dump("R1");
    // R9 unmapped offsets
    wr(12'h401, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h40B, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h422, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h460, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h401, "R9"); rd(12'h402, "R9"); rd(12'h40B, "R9");
    rd(12'h42F, "R9"); rd(12'h460, "R9"); rd(12'h461, "R9"); rd(12'hFFF, "R9");
    dump("R9");
    wr(12'h400, 64'h0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule